// File: doc/BRIEF.md
# Infrared Return-to-Zero Pulse Modulator

This block turns the serial transmit level of a UART into the short-pulse stream that drives an infrared transceiver. It runs from a bit-clock enable that fires sixteen times per baud interval. Each group of sixteen enabled clocks forms one bit period, and each period is split into sixteen numbered slots. The block reads the transmit level once, as a new period starts, and keeps that value for the whole period. The output pattern for that period comes from the value it read.

A zero bit produces one active-high pulse three slots wide, placed near the middle of the period. A one bit produces no pulse. An idle line, which stays high, therefore keeps the optical emitter dark. The slot counter runs freely and the output comes straight from a flip-flop, so the emitter never sees decode glitches.

Top module: `irmod_top`

## Requirements
- R1: A bit period lasts exactly 16 enabled clocks. The slot counter steps 0, 1, …, 15 and then returns to 0.
- R2: For a zero bit, `txIr` is high in slots 7, 8 and 9 (slots counted from 0) and low in all other slots of that period.
- R3: For a one bit, `txIr` stays low in all 16 slots of the period.
- R4: `txIn` is sampled only on the enabled edge that enters slot 0. Changes on `txIn` at any later point in the period have no effect on that period's output.
- R5: On a clock where `bitClkEn` is low, neither the slot counter nor `txIr` changes. The pulse pattern picks up where it stopped once the enable returns.
- R6: A synchronous `rst` clears the slot counter to 0, drives `txIr` low and loads the stored bit with the idle value 1. The rest of that period (slots 1 to 15) therefore stays low whatever `txIn` is.
- R7: `txIr` changes only on an enabled clock edge and always takes the value that belongs to the slot being entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bitClkEn | input | 1 | Bit-clock enable, 16 pulses per baud interval |
| txIn | input | 1 | Serial transmit level from the UART (1 = idle/mark) |
| txIr | output | 1 | Registered infrared pulse output, active high |

## Verification
The bench builds the block with its default parameters: 16 slots per bit, and a pulse that starts at slot 7 and lasts 3 slots. This setting makes the exact slot positions of the zero-bit pulse observable. It also shows the wrap from slot 15 to slot 0, where the next bit is captured. The bench toggles `txIn` in the middle of a period, inserts gaps in the enable partway through a period, and resets the block in the middle of a pulse. Together these show that the stored bit and the slot count are insulated from such events.

// File: rtl/irmod_pkg.sv
package irmod_pkg;

  // Strobes from the slot sequencer to the output datapath
  typedef struct packed {
    logic adv;        // enabled clock: state may move this cycle
    logic latchBit;   // next slot is slot 0: capture the transmit level
    logic pulseSlot;  // next slot lies inside the pulse window
  } strobe_t;

endpackage

// File: rtl/irmod_ctrl.sv
module irmod_ctrl #(
  parameter int SLOTS_PER_BIT = 16,
  parameter int PULSE_START   = 7,
  parameter int PULSE_LEN     = 3,
  localparam int SLOT_W       = $clog2(SLOTS_PER_BIT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bitClkEn,
  output irmod_pkg::strobe_t   strobe,
  output logic [SLOT_W-1:0]    slotIdx
);

  localparam int LAST_SLOT = SLOTS_PER_BIT - 1;
  localparam int PULSE_END = PULSE_START + PULSE_LEN - 1;

  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] nextSlot;
  logic              inWindow;

  always_comb begin
    if (slotCnt == SLOT_W'(LAST_SLOT)) nextSlot = '0;
    else                               nextSlot = slotCnt + 1'b1;
  end

  generate
    if (PULSE_LEN > 0) begin : g_window
      always_comb inWindow = (int'(nextSlot) >= PULSE_START) &&
                             (int'(nextSlot) <= PULSE_END);
    end else begin : g_nowindow
      always_comb inWindow = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           slotCnt <= '0;
    else if (bitClkEn) slotCnt <= nextSlot;
  end

  always_comb begin
    strobe.adv       = bitClkEn;
    strobe.latchBit  = bitClkEn && (nextSlot == '0);
    strobe.pulseSlot = inWindow;
  end

  assign slotIdx = slotCnt;

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (bitClkEn && slotCnt == SLOT_W'(LAST_SLOT)) |=> (slotCnt == '0)); // R1

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bitClkEn |=> $stable(slotCnt)); // R5

endmodule

// File: rtl/irmod_dp.sv
module irmod_dp (
  input  logic               clk,
  input  logic               rst,
  input  irmod_pkg::strobe_t strobe,
  input  logic               txIn,
  output logic               txIr
);

  logic txBit;  // level captured at the start of the current period

  always_ff @(posedge clk) begin
    if (rst) begin
      txBit <= 1'b1;
      txIr  <= 1'b0;
    end else if (strobe.adv) begin
      if (strobe.latchBit) txBit <= txIn;
      txIr <= strobe.pulseSlot && !txBit;
    end
  end

  AST_ONE_DARK: assert property (@(posedge clk) disable iff (rst)
    txIr |-> !txBit); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.adv |=> $stable(txIr)); // R5

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.latchBit |=> $stable(txBit)); // R4

endmodule

// File: rtl/irmod_top.sv
module irmod_top #(
  parameter int SLOTS_PER_BIT = 16,
  parameter int PULSE_START   = 7,
  parameter int PULSE_LEN     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bitClkEn,
  input  logic txIn,
  output logic txIr
);

  localparam int SLOT_W    = $clog2(SLOTS_PER_BIT);
  localparam int PULSE_END = PULSE_START + PULSE_LEN - 1;

  irmod_pkg::strobe_t strobe;
  logic [SLOT_W-1:0]  slotIdx;

  irmod_ctrl #(
    .SLOTS_PER_BIT(SLOTS_PER_BIT),
    .PULSE_START  (PULSE_START),
    .PULSE_LEN    (PULSE_LEN)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .bitClkEn(bitClkEn),
    .strobe  (strobe),
    .slotIdx (slotIdx)
  );

  irmod_dp i_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .txIn  (txIn),
    .txIr  (txIr)
  );

  AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    txIr |-> (int'(slotIdx) >= PULSE_START && int'(slotIdx) <= PULSE_END)); // R2

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!txIr && slotIdx == '0)); // R6

endmodule

// File: tb/test_irmod_top.sv
module test_irmod_top;

  localparam int SLOTS = 16;
  localparam int PSTART = 7;
  localparam int PEND = 9;
  localparam int NVEC = 8;
  // each entry: {bit to send, toggle txIn mid-period, enable gap mid-period}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b000, 3'b100, 3'b000, 3'b010, 3'b110, 3'b001, 3'b101, 3'b011
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitClkEn = 1'b0;
  logic txIn = 1'b1;
  logic txIr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irmod_top i_irmod_top (
    .clk(clk), .rst(rst), .bitClkEn(bitClkEn), .txIn(txIn), .txIr(txIr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: txIr=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expOut(input int slot, input logic b);
    return (slot >= PSTART && slot <= PEND) && !b;
  endfunction

  // one period: entry edge into slot 0 samples txIn = b
  task automatic runPeriod(input logic b, input logic flip, input logic gap);
    txIn = b;
    bitClkEn = 1'b1;
    for (int s = 0; s < SLOTS; s++) begin
      tick();
      check(txIr, expOut(s, b), b ? "R3 one bit dark" : "R2 zero bit pulse");
      if (s == 0 && flip) txIn = ~b;          // R4 mid-period change
      if (s == 8 && gap) begin                 // R5 enable gap
        bitClkEn = 1'b0;
        for (int g = 0; g < 3; g++) begin
          tick();
          check(txIr, expOut(s, b), "R5 hold without enable");
        end
        bitClkEn = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: timeout actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    txIn = 1'b0;
    bitClkEn = 1'b1;
    repeat (3) tick();
    check(txIr, 1'b0, "R6 reset output low");
    rst = 1'b0;
    // R6: rest of first period idle even though txIn is 0
    for (int s = 1; s < SLOTS; s++) begin
      tick();
      check(txIr, 1'b0, "R6 idle after reset");
    end
    // table walk (R1 alignment across consecutive periods, R2, R3, R4, R5)
    for (int i = 0; i < NVEC; i++)
      runPeriod(VEC[i][2], VEC[i][1], VEC[i][0]);

    // R7: output follows only enabled edges, sparse enable
    txIn = 1'b0;
    tick();  // enters slot 0 of a zero period
    check(txIr, 1'b0, "R7 slot0");
    for (int s = 1; s < SLOTS; s++) begin
      bitClkEn = 1'b0;
      tick();
      check(txIr, expOut(s - 1, 1'b0), "R7 no edge no change");
      bitClkEn = 1'b1;
      tick();
      check(txIr, expOut(s, 1'b0), "R7 enabled edge");
    end

    // R6: reset in the middle of a pulse
    txIn = 1'b0;
    for (int s = 0; s < 9; s++) tick();       // now in slot 8
    check(txIr, 1'b1, "R2 pulse before reset");
    rst = 1'b1;
    tick();
    check(txIr, 1'b0, "R6 reset mid pulse");
    rst = 1'b0;
    for (int s = 1; s < SLOTS; s++) begin
      tick();
      check(txIr, 1'b0, "R6 idle period after reset");
    end
    // R1: realignment, next period starts cleanly at slot 0
    runPeriod(1'b0, 1'b0, 1'b0);
    runPeriod(1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule